// File: doc/BRIEF.md
# Long Register Window Bridge

This block is a slave on a 32-bit short-register bus. Behind it sits a bank of 64-bit long registers that the bus cannot reach directly. The host reaches them through four short registers, called windows:

- the address window, which selects a long register;
- the low-data and high-data windows, which stage the two halves of a 64-bit value;
- the strobe window, which triggers the transfer.

A **write to the strobe** commits the staged 64-bit value to the long register that the address window selects. A **read of the strobe** copies that long register into a 64-bit snapshot. The host then reads the snapshot through the high and low windows, in either order.

The bank holds the following long registers:

| Long address | Content | Access |
|---|---|---|
| 0 | channel mask | write-only |
| 1 | clock divider | write-only |
| 2 | trigger value | write-only |
| 3 | trigger type | write-only |
| 4 | trigger enable | write-only |
| 5 | memory fill limit | read/write |
| 7 | elapsed time (from input port) | read-only |
| 8 | current input levels (from input port) | read-only |
| 9 | capture status (from input port) | read-only |
| 10 | capture control | read/write (bit 0 only reads back) |
| 100 | constant test-ID word | read-only |

The capture-control register holds a trigger-enable level. It also has four command bits that only ever appear as one-cycle pulses.

A small sequencer sits behind the strobe. It has three states:

- `ST_IDLE`: no transfer pending.
- `ST_COMMIT`: the bank is written at the end of this cycle.
- `ST_SNAP`: the snapshot is loaded at the end of this cycle.

The sequencer moves between states as follows, from any state:

- a strobe write (a write takes priority) goes to `ST_COMMIT`;
- otherwise, a strobe read goes to `ST_SNAP`;
- otherwise, the sequencer returns to `ST_IDLE`.

The staging registers and the selected address are sampled at the edge that leaves `ST_COMMIT` or `ST_SNAP`. A window write made during that cycle therefore takes effect only for the next transfer.

Top module: `long_reg_bridge`

## Requirements
- R1: After reset the following are all zero: every config output, `cap_trg_en`, the four pulse outputs, `bus_rvalid` and the snapshot. Reading the low or high window before any strobe read therefore returns 0.
- R2: Writing address 0x10B4, then 0x10B8 (low half), then 0x10BC (high half), then writing 0x10B0 (strobe) commits {high, low} to the long register selected by the address window. Long registers 0..5 appear on `cfg_chan_mask`, `cfg_div_count`, `cfg_trg_value`, `cfg_trg_type`, `cfg_trg_enable` and `cfg_fill_limit` respectively, from the second rising edge after the strobe-write cycle. With no commit, these outputs hold.
- R3: A read of 0x10B0 returns 0. It loads the selected long register into the snapshot at the second rising edge after the read cycle. Reads of 0x10BC and 0x10B8 then return the snapshot's upper and lower 32 bits. The snapshot does not change until the next strobe read, even if the address or data windows are written or the source changes.
- R4: A read request is answered one cycle later: `bus_rvalid` is high for that single cycle, with `bus_rdata` valid in the same cycle. A read of 0x10B4 returns the staged long address. Unmapped short addresses read 0. `bus_rvalid` is low in cycles that follow no read. A read asserted together with a write is ignored.
- R5: Long register 100 reads as 0x1234567887654321. A window read taken before any strobe read returns the earlier snapshot (zero after reset), not the test word.
- R6: Long register 10 (capture control) works as follows:
  - Bit 0 sets the held `cap_trg_en`.
  - Bits 2, 4, 5 and 6 drive `cap_clr_timebase`, `cap_flush_fifo`, `cap_clr_fifofull` and `cap_clr_counter` for exactly the one cycle that follows the commit edge.
  - A readback returns only bit 0.
  - Commits to any other address leave all pulse outputs low.
- R7: Long registers 0..4 read as 0. Long register 5 reads back the committed value.
- R8: Long registers 7, 8 and 9 read as `stat_elapsed`, `stat_levels` and `stat_flags`, sampled at the snapshot edge. Writes to them change no output.
- R9: Writes to the undefined long addresses, and to 100, change no config output and do not change `cap_trg_en`. Every long address the bank does not define reads as 0. Long addresses are compared on all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Short-register byte address |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read response strobe |
| stat_elapsed | input | 64 | Elapsed-time source for long register 7 |
| stat_levels | input | 64 | Input-level source for long register 8 |
| stat_flags | input | 64 | Status source for long register 9 |
| cfg_chan_mask | output | 64 | Long register 0 |
| cfg_div_count | output | 64 | Long register 1 |
| cfg_trg_value | output | 64 | Long register 2 |
| cfg_trg_type | output | 64 | Long register 3 |
| cfg_trg_enable | output | 64 | Long register 4 |
| cfg_fill_limit | output | 64 | Long register 5 |
| cap_trg_en | output | 1 | Held trigger enable |
| cap_clr_timebase | output | 1 | One-cycle timebase clear |
| cap_flush_fifo | output | 1 | One-cycle FIFO flush |
| cap_clr_fifofull | output | 1 | One-cycle FIFO-full clear |
| cap_clr_counter | output | 1 | One-cycle counter clear |

## Verification
Each result is due a fixed number of cycles after its stimulus:

- Short-register read data and `bus_rvalid` are due one rising edge after the request.
- Config outputs and capture pulses are due at the second rising edge after a strobe write. The pulses fall again one edge later.
- The snapshot is loaded at the second edge after a strobe read.

The bench drives every request on a falling edge and holds it for one full cycle. It samples results on the falling edge at exactly these offsets, so the pulse checks see the one high cycle and the low cycle after it. The checks sweep the following, comparing each result with a value computed arithmetically in the bench:

- long addresses 0..127;
- two values that differ from 10 and 100 only in their upper bits;
- all 128 combinations of the capture-control low bits.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SNAP   = 2'd2
    } seq_state_t;

    // long register numbers
    localparam int LA_FILL    = 5;
    localparam int LA_ELAPSED = 7;
    localparam int LA_LEVELS  = 8;
    localparam int LA_FLAGS   = 9;
    localparam int LA_CAPCTL  = 10;
    localparam int LA_TESTID  = 100;

    // writable config registers occupy long addresses 0 .. N_CFG-1
    localparam int N_CFG = 6;

    localparam logic [63:0] TEST_WORD = 64'h1234_5678_8765_4321;

    // capture control bit positions
    localparam int CC_TRG      = 0;
    localparam int CC_CLR_TB   = 2;
    localparam int CC_FLUSH    = 4;
    localparam int CC_CLR_FULL = 5;
    localparam int CC_CLR_CNT  = 6;

    localparam int N_PULSE = 4;

endpackage

// File: rtl/lrb_seq_fsm.sv
module lrb_seq_fsm
    import lrb_pkg::*;
#(
    parameter int            AW          = 16,
    parameter logic [AW-1:0] STROBE_ADDR = 16'h10B0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic          commit_en,
    output logic          snap_en
);

    seq_state_t state, state_nxt;

    logic strobe_wr;
    logic strobe_rd;

    assign strobe_wr = bus_wr && (bus_addr == STROBE_ADDR);
    assign strobe_rd = bus_rd && !bus_wr && (bus_addr == STROBE_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_COMMIT, ST_SNAP: begin
                if (strobe_wr) begin
                    state_nxt = ST_COMMIT;
                end else if (strobe_rd) begin
                    state_nxt = ST_SNAP;
                end else begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        commit_en = 1'b0;
        snap_en   = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_COMMIT: commit_en = 1'b1;
            ST_SNAP:   snap_en   = 1'b1;
            default:   ;
        endcase
    end

    // R2: a strobe write always leads to a commit cycle
    p_strobe_wr_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STROBE_ADDR) |=> commit_en && !snap_en);

    // R3: a strobe read without a write leads to a snapshot cycle
    p_strobe_rd_snap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == STROBE_ADDR) |=> snap_en && !commit_en);

    // R2: no strobe, no transfer
    p_no_strobe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !((bus_wr || bus_rd) && bus_addr == STROBE_ADDR) |=> !commit_en && !snap_en);

endmodule

// File: rtl/lrb_windows.sv
module lrb_windows #(
    parameter int            AW          = 16,
    parameter int            DW          = 32,
    parameter logic [AW-1:0] STROBE_ADDR = 16'h10B0,
    parameter logic [AW-1:0] LADDR_ADDR  = 16'h10B4,
    parameter logic [AW-1:0] LOW_ADDR    = 16'h10B8,
    parameter logic [AW-1:0] HIGH_ADDR   = 16'h10BC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [2*DW-1:0] snap_value,
    output logic [DW-1:0]   stage_addr,
    output logic [2*DW-1:0] stage_data,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_rvalid
);

    localparam int LW = 2 * DW;

    logic [DW-1:0] addr_q;
    logic [DW-1:0] low_q;
    logic [DW-1:0] high_q;
    logic [DW-1:0] rd_sel;
    logic          rd_fire;

    assign rd_fire    = bus_rd && !bus_wr;
    assign stage_addr = addr_q;
    assign stage_data = {high_q, low_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == LADDR_ADDR) addr_q <= bus_wdata;
            if (bus_addr == LOW_ADDR)   low_q  <= bus_wdata;
            if (bus_addr == HIGH_ADDR)  high_q <= bus_wdata;
        end
    end

    always_comb begin
        rd_sel = '0;
        if (bus_addr == LADDR_ADDR) begin
            rd_sel = addr_q;
        end else if (bus_addr == LOW_ADDR) begin
            rd_sel = snap_value[DW-1:0];
        end else if (bus_addr == HIGH_ADDR) begin
            rd_sel = snap_value[LW-1:DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_fire;
            bus_rdata  <= rd_fire ? rd_sel : '0;
        end
    end

    // R4: every accepted read is answered in the next cycle
    p_read_answered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> bus_rvalid);

    // R4: no response without a request
    p_no_spurious_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> !bus_rvalid);

    // R3: the strobe window reads as zero
    p_strobe_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == STROBE_ADDR) |=> bus_rdata == '0);

endmodule

// File: rtl/lrb_bank.sv
module lrb_bank
    import lrb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit_en,
    input  logic                         snap_en,
    input  logic [DW-1:0]                sel_addr,
    input  logic [2*DW-1:0]              wr_data,
    input  logic [2*DW-1:0]              stat_elapsed,
    input  logic [2*DW-1:0]              stat_levels,
    input  logic [2*DW-1:0]              stat_flags,
    output logic [N_CFG-1:0][2*DW-1:0]   cfg_out,
    output logic                         trg_en,
    output logic [N_PULSE-1:0]           pulse,
    output logic [2*DW-1:0]              snap_q
);

    localparam int LW = 2 * DW;

    logic [LW-1:0] cfg_q [N_CFG];
    logic [LW-1:0] rd_mux;
    logic          hit_capctl;

    assign hit_capctl = (sel_addr == DW'(LA_CAPCTL));

    for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (commit_en && sel_addr == DW'(g)) begin
                cfg_q[g] <= wr_data;
            end
        end
        assign cfg_out[g] = cfg_q[g];
    end

    // capture control: bit 0 held, command bits pulse for one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trg_en <= 1'b0;
            pulse  <= '0;
        end else if (commit_en && hit_capctl) begin
            trg_en <= wr_data[CC_TRG];
            pulse  <= {wr_data[CC_CLR_CNT], wr_data[CC_CLR_FULL],
                       wr_data[CC_FLUSH],   wr_data[CC_CLR_TB]};
        end else begin
            pulse  <= '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (sel_addr == DW'(LA_FILL)) begin
            rd_mux = cfg_q[LA_FILL];
        end else if (sel_addr == DW'(LA_ELAPSED)) begin
            rd_mux = stat_elapsed;
        end else if (sel_addr == DW'(LA_LEVELS)) begin
            rd_mux = stat_levels;
        end else if (sel_addr == DW'(LA_FLAGS)) begin
            rd_mux = stat_flags;
        end else if (hit_capctl) begin
            rd_mux = LW'(trg_en);
        end else if (sel_addr == DW'(LA_TESTID)) begin
            rd_mux = LW'(TEST_WORD);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (snap_en) begin
            snap_q <= rd_mux;
        end
    end

    // R6: a pulse is only seen right after a capture-control commit
    p_pulse_after_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse) |-> ($past(commit_en) && $past(sel_addr) == DW'(LA_CAPCTL)));

    // R2: config registers hold while nothing is committed
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |=> $stable(cfg_out) && $stable(trg_en));

    // R9 (and R8): commits outside the writable set leave the outputs alone
    p_ignored_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && sel_addr >= DW'(N_CFG) && !hit_capctl)
        |=> $stable(cfg_out) && $stable(trg_en) && pulse == '0);

    // R5: a snapshot of the test register yields the constant word
    p_test_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_en && sel_addr == DW'(LA_TESTID)) |=> snap_q == LW'(TEST_WORD));

    // R3: the snapshot moves only on a snapshot cycle
    p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_en |=> $stable(snap_q));

endmodule

// File: rtl/long_reg_bridge.sv
module long_reg_bridge
    import lrb_pkg::*;
#(
    parameter int            AW          = 16,
    parameter int            DW          = 32,
    parameter logic [AW-1:0] STROBE_ADDR = 16'h10B0,
    parameter logic [AW-1:0] LADDR_ADDR  = 16'h10B4,
    parameter logic [AW-1:0] LOW_ADDR    = 16'h10B8,
    parameter logic [AW-1:0] HIGH_ADDR   = 16'h10BC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_rvalid,
    input  logic [2*DW-1:0] stat_elapsed,
    input  logic [2*DW-1:0] stat_levels,
    input  logic [2*DW-1:0] stat_flags,
    output logic [2*DW-1:0] cfg_chan_mask,
    output logic [2*DW-1:0] cfg_div_count,
    output logic [2*DW-1:0] cfg_trg_value,
    output logic [2*DW-1:0] cfg_trg_type,
    output logic [2*DW-1:0] cfg_trg_enable,
    output logic [2*DW-1:0] cfg_fill_limit,
    output logic            cap_trg_en,
    output logic            cap_clr_timebase,
    output logic            cap_flush_fifo,
    output logic            cap_clr_fifofull,
    output logic            cap_clr_counter
);

    localparam int LW = 2 * DW;

    logic                      commit_en;
    logic                      snap_en;
    logic [DW-1:0]             stage_addr;
    logic [LW-1:0]             stage_data;
    logic [LW-1:0]             snap_q;
    logic [N_CFG-1:0][LW-1:0]  cfg_out;
    logic [N_PULSE-1:0]        pulse;

    lrb_seq_fsm #(
        .AW          (AW),
        .STROBE_ADDR (STROBE_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .commit_en (commit_en),
        .snap_en   (snap_en)
    );

    lrb_windows #(
        .AW          (AW),
        .DW          (DW),
        .STROBE_ADDR (STROBE_ADDR),
        .LADDR_ADDR  (LADDR_ADDR),
        .LOW_ADDR    (LOW_ADDR),
        .HIGH_ADDR   (HIGH_ADDR)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .snap_value (snap_q),
        .stage_addr (stage_addr),
        .stage_data (stage_data),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    lrb_bank #(
        .DW (DW)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_en    (commit_en),
        .snap_en      (snap_en),
        .sel_addr     (stage_addr),
        .wr_data      (stage_data),
        .stat_elapsed (stat_elapsed),
        .stat_levels  (stat_levels),
        .stat_flags   (stat_flags),
        .cfg_out      (cfg_out),
        .trg_en       (cap_trg_en),
        .pulse        (pulse),
        .snap_q       (snap_q)
    );

    assign cfg_chan_mask    = cfg_out[0];
    assign cfg_div_count    = cfg_out[1];
    assign cfg_trg_value    = cfg_out[2];
    assign cfg_trg_type     = cfg_out[3];
    assign cfg_trg_enable   = cfg_out[4];
    assign cfg_fill_limit   = cfg_out[5];

    assign cap_clr_timebase = pulse[0];
    assign cap_flush_fifo   = pulse[1];
    assign cap_clr_fifofull = pulse[2];
    assign cap_clr_counter  = pulse[3];

    // R1: nothing is pending or pulsing in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !bus_rvalid && pulse == '0);

endmodule

// File: tb/long_reg_bridge_tb_top.sv
module long_reg_bridge_tb_top;

    localparam logic [15:0] A_STB = 16'h10B0;
    localparam logic [15:0] A_ADR = 16'h10B4;
    localparam logic [15:0] A_LO  = 16'h10B8;
    localparam logic [15:0] A_HI  = 16'h10BC;
    localparam logic [63:0] ID_WORD = 64'h1234_5678_8765_4321;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [63:0] stat_elapsed = 64'h0000_0011_2233_4455;
    logic [63:0] stat_levels  = 64'h0000_0003_DEAD_BEEF;
    logic [63:0] stat_flags   = 64'h0000_0000_0000_003F;
    logic [63:0] cfg_chan_mask, cfg_div_count, cfg_trg_value;
    logic [63:0] cfg_trg_type, cfg_trg_enable, cfg_fill_limit;
    logic        cap_trg_en, cap_clr_timebase, cap_flush_fifo;
    logic        cap_clr_fifofull, cap_clr_counter;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] m_cfg [0:5];
    logic        m_trg;

    always #4 clk = ~clk;

    long_reg_bridge dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
        .stat_elapsed (stat_elapsed), .stat_levels (stat_levels), .stat_flags (stat_flags),
        .cfg_chan_mask (cfg_chan_mask), .cfg_div_count (cfg_div_count),
        .cfg_trg_value (cfg_trg_value), .cfg_trg_type (cfg_trg_type),
        .cfg_trg_enable (cfg_trg_enable), .cfg_fill_limit (cfg_fill_limit),
        .cap_trg_en (cap_trg_en), .cap_clr_timebase (cap_clr_timebase),
        .cap_flush_fifo (cap_flush_fifo), .cap_clr_fifofull (cap_clr_fifofull),
        .cap_clr_counter (cap_clr_counter)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_long(input logic [31:0] a);
        logic [63:0] v;
        v = '0;
        if (a == 32'd5)        v = m_cfg[5];
        else if (a == 32'd7)   v = stat_elapsed;
        else if (a == 32'd8)   v = stat_levels;
        else if (a == 32'd9)   v = stat_flags;
        else if (a == 32'd10)  v = {63'b0, m_trg};
        else if (a == 32'd100) v = ID_WORD;
        return v;
    endfunction

    function automatic string req_of(input logic [31:0] a);
        if (a <= 32'd5)                  return "R7";
        if (a >= 32'd7 && a <= 32'd9)    return "R8";
        if (a == 32'd10)                 return "R6";
        if (a == 32'd100)                return "R5";
        return "R9";
    endfunction

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R4 rvalid on response", {63'b0, bus_rvalid}, 64'd1);
        d = bus_rdata;
    endtask

    task automatic check_cfg(input string req);
        chk(req, cfg_chan_mask,  m_cfg[0]);
        chk(req, cfg_div_count,  m_cfg[1]);
        chk(req, cfg_trg_value,  m_cfg[2]);
        chk(req, cfg_trg_type,   m_cfg[3]);
        chk(req, cfg_trg_enable, m_cfg[4]);
        chk(req, cfg_fill_limit, m_cfg[5]);
        chk(req, {63'b0, cap_trg_en}, {63'b0, m_trg});
    endtask

    // full write sequence; checks outputs at the second edge after the strobe
    task automatic long_write(input logic [31:0] a, input logic [63:0] v);
        logic [3:0] exp_p;
        bus_write(A_ADR, a);
        bus_write(A_LO,  v[31:0]);
        bus_write(A_HI,  v[63:32]);
        bus_write(A_STB, 32'h0);
        @(negedge clk);
        exp_p = '0;
        if (a <= 32'd5) m_cfg[a] = v;
        if (a == 32'd10) begin
            m_trg = v[0];
            exp_p = {v[6], v[5], v[4], v[2]};
        end
        check_cfg((a <= 32'd5) ? "R2 committed config" : "R9 ignored write / R6 capctl");
        chk("R6 clr_timebase pulse", {63'b0, cap_clr_timebase}, {63'b0, exp_p[0]});
        chk("R6 flush_fifo pulse",   {63'b0, cap_flush_fifo},   {63'b0, exp_p[1]});
        chk("R6 clr_fifofull pulse", {63'b0, cap_clr_fifofull}, {63'b0, exp_p[2]});
        chk("R6 clr_counter pulse",  {63'b0, cap_clr_counter},  {63'b0, exp_p[3]});
        @(negedge clk);
        chk("R6 pulses single cycle",
            {60'b0, cap_clr_counter, cap_clr_fifofull, cap_flush_fifo, cap_clr_timebase}, 64'd0);
        chk("R6 trg_en held", {63'b0, cap_trg_en}, {63'b0, m_trg});
    endtask

    task automatic long_read(input logic [31:0] a, output logic [63:0] v);
        logic [31:0] d, h, l;
        bus_write(A_ADR, a);
        bus_read(A_STB, d);
        chk("R3 strobe reads zero", {32'b0, d}, 64'd0);
        bus_read(A_HI, h);
        bus_read(A_LO, l);
        v = {h, l};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [31:0] d;
        for (int i = 0; i < 6; i++) m_cfg[i] = '0;
        m_trg = 1'b0;

        repeat (3) @(negedge clk);
        // R1: reset values
        check_cfg("R1 reset config");
        chk("R1 reset pulses",
            {60'b0, cap_clr_counter, cap_clr_fifofull, cap_flush_fifo, cap_clr_timebase}, 64'd0);
        chk("R1 reset rvalid", {63'b0, bus_rvalid}, 64'd0);
        rst_n = 1'b1;

        // R5: window before any strobe read is stale (zero)
        bus_write(A_ADR, 32'd100);
        bus_read(A_LO, d);
        chk("R5 stale low before latch", {32'b0, d}, 64'd0);
        bus_read(A_HI, d);
        chk("R1 R5 stale high before latch", {32'b0, d}, 64'd0);
        long_read(32'd100, v);
        chk("R5 test word", v, ID_WORD);

        // R4: address window readback, unmapped short address, idle rvalid
        bus_read(A_ADR, d);
        chk("R4 address window readback", {32'b0, d}, 64'd100);
        bus_read(16'h1000, d);
        chk("R4 unmapped short reads zero", {32'b0, d}, 64'd0);
        @(negedge clk);
        chk("R4 rvalid low when idle", {63'b0, bus_rvalid}, 64'd0);

        // sweep of the long address space
        for (int a = 0; a < 130; a++) begin
            logic [31:0] la;
            logic [63:0] pat;
            la = (a < 128) ? 32'(a) : ((a == 128) ? 32'h0001_000A : 32'h0001_0064);
            pat = {32'h5A00_0000 ^ (la << 8), 32'hC0DE_0000 | la};
            long_write(la, pat);
            long_read(la, v);
            chk(req_of(la), v, exp_long(la));
        end

        // R6: all combinations of capture-control low bits
        for (int m = 0; m < 128; m++) begin
            long_write(32'd10, {57'b0, 7'(m)});
        end
        long_write(32'd10, 64'h1);
        long_read(32'd10, v);
        chk("R6 capctl readback bit0 only", v, 64'd1);

        // R3: snapshot is unaffected by later window writes
        long_write(32'd5, 64'hFEED_0001_0BAD_F00D);
        long_read(32'd5, v);
        chk("R7 fill limit readback", v, 64'hFEED_0001_0BAD_F00D);
        bus_write(A_ADR, 32'd7);
        bus_write(A_LO, 32'h1111_1111);
        bus_read(A_HI, d);
        chk("R3 snapshot high holds", {32'b0, d}, 64'h0000_0000_FEED_0001);
        bus_read(A_LO, d);
        chk("R3 snapshot low holds", {32'b0, d}, 64'h0000_0000_0BAD_F00D);

        // R8: status sampled at latch edge only
        stat_levels = 64'h0000_0001_2345_6789;
        long_read(32'd8, v);
        chk("R8 levels sampled", v, 64'h0000_0001_2345_6789);
        stat_levels = 64'h0000_0002_AAAA_5555;
        bus_read(A_HI, d);
        chk("R3 R8 snapshot keeps old levels", {32'b0, d}, 64'h1);
        long_read(32'd8, v);
        chk("R8 levels resampled", v, 64'h0000_0002_AAAA_5555);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule